// File: doc/BRIEF.md
# Strobed Serial Divider Programming Port

This block sits in front of a clock synthesizer. It shares a 4-bit select bus between two jobs. Each bus write is qualified by a strobe whose active edge or level is fixed by a parameter. An ordinary write latches a frequency-select index. That index picks one entry of a divider register file, and the entry's feedback divider, post-divider and external-source flag are driven out continuously.

A programming frame can begin only after the bus has been quiet for a parameterised number of reference-clock cycles. That quiet period empties the shift register. The frame is then sent serially over two bus lines: bit 3 is the clocking line and bit 2 is the data line. Each frame bit takes two writes, the first with the clocking line at 0 and the second with it at 1. The data bit is taken from the second write.

After 20 bits the framing bits are checked. A good frame either writes one register-file location or raises a read request. A frame that stalls, breaks framing or breaks the two-write rhythm is dropped and flagged.

Top module: `clksyn_prog_port`

## Requirements
- R1: With the default rising-edge mode, a write is taken on the 0-to-1 transition of `strobe` only. Changing `sel_bus` while `strobe` stays high, and then dropping `strobe`, causes no write.
- R2: A plain write loads `sel_bus` into `sel_idx`, visible one cycle after the write. The outputs `vclk_fb`, `vclk_post` and `vclk_ext` always show the entry that `sel_idx` selects.
- R3: After reset, `sel_idx` is 0. Every entry i holds feedback value i, post-divider 0 and external flag 0. All pulses are low.
- R4: A frame opens only on a write with bit 3 equal to 0 that arrives after `IDLE_CYCLES` reference-clock cycles with no write. Any earlier write restarts the idle count and is a plain write. After the idle time, a write with bit 3 equal to 1 is also a plain write.
- R5: Inside a frame, each bit is a write with bit 3 = 0 followed by a write with bit 3 = 1. The bit value is `sel_bus[2]` on the second write. Two successive writes with the same bit-3 value abort the frame with `frame_err`.
- R6: Frame bit k, counted from 0, has this meaning:
  - bit 0: start bit, must be 0
  - bit 1: read/write flag
  - bits 2-6: location, LSB first
  - bits 7-14: feedback divider, LSB first
  - bit 15: external flag
  - bits 16-17: post-divider, LSB first
  - bits 18-19: stop bits, both must be 1

  A correct frame with the read/write flag at 0 writes the entry. It also gives a one-cycle `frame_done` pulse.
- R7: A frame with start bit 1 or either stop bit 0 pulses `frame_err` and leaves the register file unchanged.
- R8: A correct write frame with location 16 or more pulses `frame_done` and writes no entry.
- R9: A correct frame with the read/write flag at 1 pulses `rd_req` for one cycle, puts the location on `rd_loc`, and writes no entry.
- R10: The external flag written by a frame appears on `vclk_ext` when that entry is selected.
- R11: A frame left idle for `IDLE_CYCLES` cycles before its 20th bit is aborted with a `frame_err` pulse.
- R12: Writes that belong to a frame never change `sel_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Write qualifier for the select bus |
| sel_bus | input | 4 | Select bus; bit 3 is the frame clocking line, bit 2 the frame data line |
| sel_idx | output | 4 | Latched frequency-select index |
| vclk_fb | output | 8 | Feedback divider of the selected entry |
| vclk_post | output | 2 | Post-divider of the selected entry |
| vclk_ext | output | 1 | External-source flag of the selected entry |
| frame_done | output | 1 | One-cycle pulse for an accepted frame |
| frame_err | output | 1 | One-cycle pulse for a dropped frame |
| rd_req | output | 1 | One-cycle pulse for a read-request frame |
| rd_loc | output | 5 | Location named by the last read request |

## Verification
The collision of interest is a frame completing its register-file write into the very entry that `sel_idx` currently points at. In that case the divider outputs must change on the cycle after the final write, while the index itself stays put. The bench first selects location 3 with plain writes and then programs location 3 through a full frame. The scoreboard compares the outputs right after the frame against the newly programmed values, with `sel_idx` still equal to 3.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  localparam int FRAME_BITS = 20;
  localparam int LOC_BITS   = 5;
  localparam int FB_BITS    = 8;
  localparam int PD_BITS    = 2;
  localparam int CLK_LINE   = 3;
  localparam int DAT_LINE   = 2;
  localparam int POS_START  = 0;
  localparam int POS_RW     = 1;
  localparam int POS_LOC    = 2;
  localparam int POS_FB     = 7;
  localparam int POS_EXT    = 15;
  localparam int POS_PD     = 16;
  localparam int POS_STOP_A = 18;
  localparam int POS_STOP_B = 19;

  typedef enum logic [1:0] {
    STB_RISE = 2'd0,
    STB_FALL = 2'd1,
    STB_HIGH = 2'd2,
    STB_LOW  = 2'd3
  } stb_mode_e;

  typedef struct packed {
    logic               ext;
    logic [PD_BITS-1:0] pdiv;
    logic [FB_BITS-1:0] fbdiv;
  } div_entry_t;
endpackage

// File: rtl/clksyn_strobe_detect.sv
module clksyn_strobe_detect
  import clksyn_pkg::*;
#(
  parameter stb_mode_e MODE = STB_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic wr_evt,
  output logic open_win
);
  localparam logic IDLE_LVL = (MODE == STB_FALL) || (MODE == STB_LOW);

  logic stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= IDLE_LVL;
    else        stb_q <= strobe;
  end

  generate
    if (MODE == STB_RISE) begin : g_rise
      assign wr_evt   = strobe & ~stb_q;
      assign open_win = 1'b0;
    end else if (MODE == STB_FALL) begin : g_fall
      assign wr_evt   = ~strobe & stb_q;
      assign open_win = 1'b0;
    end else if (MODE == STB_HIGH) begin : g_high
      assign wr_evt   = ~strobe & stb_q;
      assign open_win = strobe;
    end else begin : g_low
      assign wr_evt   = strobe & ~stb_q;
      assign open_win = ~strobe;
    end
  endgenerate

  a_r1_evt_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> (strobe != stb_q));
endmodule

// File: rtl/clksyn_idle_timer.sv
module clksyn_idle_timer #(
  parameter int IDLE_CYCLES = 715900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_evt,
  output logic armed
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_evt)              cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign armed = (cnt_q == LIMIT);

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !armed);
endmodule

// File: rtl/clksyn_frame_asm.sv
module clksyn_frame_asm
  import clksyn_pkg::*;
#(
  parameter int NUM_LOC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_evt,
  input  logic [3:0]          sel_bus,
  input  logic                armed,
  output logic                in_frame,
  output logic                claim,
  output logic                we,
  output logic [LOC_BITS-1:0] waddr,
  output div_entry_t          wdata,
  output logic                done,
  output logic                err,
  output logic                rd_req,
  output logic [LOC_BITS-1:0] rd_loc
);
  localparam int BCW = $clog2(FRAME_BITS);

  logic                  in_q, in_d, half_q, half_d;
  logic [BCW-1:0]        bcnt_q, bcnt_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d, nxt_word;
  logic                  done_d, err_d, rd_d;
  logic [LOC_BITS-1:0]   rdl_q, rdl_d;
  logic                  done_q, err_q, rd_q;
  logic                  clk_ln, framing_ok, last_bit;

  assign clk_ln     = sel_bus[CLK_LINE];
  assign nxt_word   = {sel_bus[DAT_LINE], sr_q[FRAME_BITS-1:1]};
  assign framing_ok = !nxt_word[POS_START] && nxt_word[POS_STOP_A] && nxt_word[POS_STOP_B];
  assign last_bit   = (bcnt_q == BCW'(FRAME_BITS - 1));
  assign claim      = in_q || (armed && !clk_ln);

  assign waddr       = nxt_word[POS_LOC +: LOC_BITS];
  assign wdata.fbdiv = nxt_word[POS_FB +: FB_BITS];
  assign wdata.pdiv  = nxt_word[POS_PD +: PD_BITS];
  assign wdata.ext   = nxt_word[POS_EXT];

  always_comb begin
    in_d   = in_q;
    half_d = half_q;
    bcnt_d = bcnt_q;
    sr_d   = sr_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    rd_d   = 1'b0;
    rdl_d  = rdl_q;
    we     = 1'b0;
    if (in_q && armed) begin
      in_d  = 1'b0;
      err_d = 1'b1;
    end else if (wr_evt) begin
      if (!in_q) begin
        if (armed && !clk_ln) begin
          in_d   = 1'b1;
          half_d = 1'b1;
          bcnt_d = '0;
          sr_d   = '0;
        end
      end else if (half_q && clk_ln) begin
        sr_d   = nxt_word;
        half_d = 1'b0;
        bcnt_d = bcnt_q + 1'b1;
        if (last_bit) begin
          in_d = 1'b0;
          if (!framing_ok) begin
            err_d = 1'b1;
          end else begin
            done_d = 1'b1;
            if (nxt_word[POS_RW]) begin
              rd_d  = 1'b1;
              rdl_d = waddr;
            end else begin
              we = (32'(waddr) < NUM_LOC);
            end
          end
        end
      end else if (!half_q && !clk_ln) begin
        half_d = 1'b1;
      end else begin
        in_d  = 1'b0;
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= 1'b0;
      half_q <= 1'b0;
      bcnt_q <= '0;
      sr_q   <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rd_q   <= 1'b0;
      rdl_q  <= '0;
    end else begin
      in_q   <= in_d;
      half_q <= half_d;
      bcnt_q <= bcnt_d;
      sr_q   <= sr_d;
      done_q <= done_d;
      err_q  <= err_d;
      rd_q   <= rd_d;
      rdl_q  <= rdl_d;
    end
  end

  assign in_frame = in_q;
  assign done     = done_q;
  assign err      = err_q;
  assign rd_req   = rd_q;
  assign rd_loc   = rdl_q;

  a_r4_open_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_q) |-> $past(armed));
  a_r6_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q));
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r9_rd_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |-> done_q);
  a_r11_stall_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (in_q && armed) |=> (err_q && !in_q));
endmodule

// File: rtl/clksyn_div_file.sv
module clksyn_div_file
  import clksyn_pkg::*;
#(
  parameter int NUM_LOC = 16,
  localparam int IW = $clog2(NUM_LOC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [LOC_BITS-1:0] waddr,
  input  div_entry_t          wdata,
  input  logic [IW-1:0]       rsel,
  output div_entry_t          rdata
);
  div_entry_t ent_q [NUM_LOC];

  generate
    for (genvar i = 0; i < NUM_LOC; i++) begin : g_ent
      logic hit;
      assign hit = we && (waddr == LOC_BITS'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ent_q[i].ext   <= 1'b0;
          ent_q[i].pdiv  <= '0;
          ent_q[i].fbdiv <= FB_BITS'(i);
        end else if (hit) begin
          ent_q[i] <= wdata;
        end
      end
    end
  endgenerate

  assign rdata = ent_q[rsel];

  a_r8_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (32'(waddr) < NUM_LOC));
endmodule

// File: rtl/clksyn_prog_port.sv
module clksyn_prog_port
  import clksyn_pkg::*;
#(
  parameter stb_mode_e STB_MODE    = STB_RISE,
  parameter int        IDLE_CYCLES = 715900,
  parameter int        NUM_LOC     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe,
  input  logic [3:0]            sel_bus,
  output logic [3:0]            sel_idx,
  output logic [FB_BITS-1:0]    vclk_fb,
  output logic [PD_BITS-1:0]    vclk_post,
  output logic                  vclk_ext,
  output logic                  frame_done,
  output logic                  frame_err,
  output logic                  rd_req,
  output logic [LOC_BITS-1:0]   rd_loc
);
  localparam int IW = $clog2(NUM_LOC);

  logic          wr_evt, open_win, armed, in_frame, claim, we;
  logic [LOC_BITS-1:0] waddr;
  div_entry_t    wdata, cur;
  logic [3:0]    sel_q, sel_d;

  clksyn_strobe_detect #(.MODE(STB_MODE)) u_stb (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wr_evt(wr_evt), .open_win(open_win)
  );

  clksyn_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .armed(armed)
  );

  clksyn_frame_asm #(.NUM_LOC(NUM_LOC)) u_frame (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .sel_bus(sel_bus),
    .armed(armed), .in_frame(in_frame), .claim(claim), .we(we),
    .waddr(waddr), .wdata(wdata), .done(frame_done), .err(frame_err),
    .rd_req(rd_req), .rd_loc(rd_loc)
  );

  always_comb begin
    sel_d = sel_q;
    if ((wr_evt || open_win) && !claim) sel_d = sel_bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  clksyn_div_file #(.NUM_LOC(NUM_LOC)) u_file (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
    .rsel(sel_q[IW-1:0]), .rdata(cur)
  );

  assign sel_idx   = sel_q;
  assign vclk_fb   = cur.fbdiv;
  assign vclk_post = cur.pdiv;
  assign vclk_ext  = cur.ext;

  a_r12_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && (wr_evt || open_win)) |=> $stable(sel_idx));
  a_r2_plain_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && !claim) |=> (sel_idx == $past(sel_bus)));
endmodule

// File: tb/clksyn_prog_port_bench.sv
module clksyn_prog_port_bench;
  import clksyn_pkg::*;

  localparam int IDLE = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [3:0] sel_bus = 4'h0;
  logic [3:0] sel_idx;
  logic [7:0] vclk_fb;
  logic [1:0] vclk_post;
  logic       vclk_ext, frame_done, frame_err, rd_req;
  logic [4:0] rd_loc;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0, err_cnt = 0, rd_cnt = 0;
  logic [4:0] last_rd = '0;

  typedef struct {
    string      tag;
    logic [3:0] sel;
    logic [7:0] fb;
    logic [1:0] pd;
    logic       ext;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  clksyn_prog_port #(.STB_MODE(STB_RISE), .IDLE_CYCLES(IDLE), .NUM_LOC(16)) u_clksyn_prog_port (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sel_bus(sel_bus),
    .sel_idx(sel_idx), .vclk_fb(vclk_fb), .vclk_post(vclk_post),
    .vclk_ext(vclk_ext), .frame_done(frame_done), .frame_err(frame_err),
    .rd_req(rd_req), .rd_loc(rd_loc)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (frame_done) done_cnt <= done_cnt + 1;
      if (frame_err)  err_cnt  <= err_cnt + 1;
      if (rd_req) begin
        rd_cnt  <= rd_cnt + 1;
        last_rd <= rd_loc;
      end
    end
  end

  // Monitor: pops expected output snapshots and compares them.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (sel_idx !== e.sel || vclk_fb !== e.fb || vclk_post !== e.pd || vclk_ext !== e.ext) begin
          errors++;
          $display("FAIL %s: got sel=%0d fb=%h pd=%0d ext=%0b expected sel=%0d fb=%h pd=%0d ext=%0b",
                   e.tag, sel_idx, vclk_fb, vclk_post, vclk_ext, e.sel, e.fb, e.pd, e.ext);
        end
      end
    end
  end

  task automatic expect_out(input string tag, input logic [3:0] s, input logic [7:0] fb,
                            input logic [1:0] pd, input logic ext);
    exp_t e;
    e.tag = tag; e.sel = s; e.fb = fb; e.pd = pd; e.ext = ext;
    sb_q.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] v);
    @(negedge clk);
    sel_bus = v;
    strobe  = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    repeat (IDLE + 4) @(negedge clk);
  endtask

  task automatic send_bits(input logic [19:0] w, input int nbits);
    for (int k = 0; k < nbits; k++) begin
      wr({1'b0, w[k], 2'b00});
      wr({1'b1, w[k], 2'b00});
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [19:0] mk(input logic st, input logic rw, input logic [4:0] loc,
                                     input logic [7:0] fb, input logic ext, input logic [1:0] pd,
                                     input logic s1, input logic s2);
    return {s2, s1, pd, ext, fb, loc, rw, st};
  endfunction

  initial begin
    int d0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    check_int("R3 pulses idle", int'(frame_done) + int'(frame_err) + int'(rd_req), 0);
    expect_out("R3 reset entry", 4'd0, 8'd0, 2'd0, 1'b0);

    // R2 plain write before idle time
    wr(4'd5);
    expect_out("R2 plain select", 4'd5, 8'd5, 2'd0, 1'b0);

    // R4 clock line high after idle is plain; later clock-low write before idle is plain
    wait_idle();
    wr(4'b1010);
    expect_out("R4 high-line write after idle", 4'd10, 8'd10, 2'd0, 1'b0);
    wr(4'b0011);
    expect_out("R4 early write is plain", 4'd3, 8'd3, 2'd0, 1'b0);

    // R1 falling edge of strobe writes nothing
    @(negedge clk); sel_bus = 4'd2; strobe = 1'b1;
    @(negedge clk); sel_bus = 4'd6;
    @(negedge clk); strobe = 1'b0;
    @(negedge clk);
    expect_out("R1 only rising edge writes", 4'd2, 8'd2, 2'd0, 1'b0);
    wr(4'd3);

    // R6 / R12 frame writes the selected entry (collision)
    wait_idle();
    send_bits(mk(0, 0, 5'd3, 8'hA5, 0, 2'd2, 1, 1), 20);
    check_int("R6 done pulse", done_cnt, 1);
    expect_out("R6 R12 selected entry rewritten, index held", 4'd3, 8'hA5, 2'd2, 1'b0);

    // R10 external flag
    wait_idle();
    send_bits(mk(0, 0, 5'd7, 8'h3C, 1, 2'd1, 1, 1), 20);
    wr(4'd7);
    expect_out("R10 ext flag entry", 4'd7, 8'h3C, 2'd1, 1'b1);

    // R7 bad start bit
    e0 = err_cnt; d0 = done_cnt;
    wait_idle();
    send_bits(mk(1, 0, 5'd7, 8'h11, 0, 2'd0, 1, 1), 20);
    check_int("R7 bad start err", err_cnt, e0 + 1);
    expect_out("R7 bad start no write", 4'd7, 8'h3C, 2'd1, 1'b1);
    // R7 bad stop bit
    wait_idle();
    send_bits(mk(0, 0, 5'd7, 8'h22, 0, 2'd0, 1, 0), 20);
    check_int("R7 bad stop err", err_cnt, e0 + 2);
    check_int("R7 no done", done_cnt, d0);
    expect_out("R7 bad stop no write", 4'd7, 8'h3C, 2'd1, 1'b1);

    // R8 location out of range
    wait_idle();
    send_bits(mk(0, 0, 5'd20, 8'h77, 1, 2'd3, 1, 1), 20);
    check_int("R8 done for high loc", done_cnt, d0 + 1);
    wr(4'd4);
    expect_out("R8 aliased entry untouched", 4'd4, 8'd4, 2'd0, 1'b0);

    // R9 read request
    wait_idle();
    send_bits(mk(0, 1, 5'd9, 8'h55, 1, 2'd3, 1, 1), 20);
    check_int("R9 rd pulse", rd_cnt, 1);
    check_int("R9 rd loc", int'(last_rd), 9);
    wr(4'd9);
    expect_out("R9 read leaves entry", 4'd9, 8'd9, 2'd0, 1'b0);

    // R11 stalled frame
    e0 = err_cnt;
    wait_idle();
    send_bits(mk(0, 0, 5'd9, 8'hFF, 0, 2'd0, 1, 1), 5);
    wait_idle();
    check_int("R11 stall err", err_cnt, e0 + 1);
    expect_out("R11 entry unchanged", 4'd9, 8'd9, 2'd0, 1'b0);

    // R5 two clock-high writes in a row
    e0 = err_cnt;
    wr(4'b0000);
    wr(4'b1100);
    wr(4'b1100);
    repeat (2) @(negedge clk);
    check_int("R5 rhythm error", err_cnt, e0 + 1);
    wr(4'd1);
    expect_out("R5 back to plain select", 4'd1, 8'd1, 2'd0, 1'b0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule